// File: doc/BRIEF.md
# Statistics Counter Update Engine

This block applies atomic counting operations to a bank of statistics. Producers place 32-bit update words into a shared FIFO; the engine pops them one at a time and performs a read-modify-write on the target storage. There are two kinds of target. The first is a counter group of four 32-bit counters: packet and byte counters on the pre-queue side, and packet and byte counters on the post-queue side. The second is a small register file for system-wide counts. Because every update passes through this one engine, no two updates can interleave on the same counter.

Counter groups with a low index sit in on-chip flops and are updated at one command per clock. Groups above the local range sit in an external memory reached through a request/acknowledge port. Each counter that such a command touches costs one read and one write on that port, and the FIFO is not popped again until the last write completes. A combinational debug port reads any on-chip counter or register.

Top module: `stats_engine`

## Requirements
- R1: A command word holds the opcode in [31:28], a 12-bit data value in [27:16] and the index in [15:0]. Opcode bit 3 = 0 selects a counter group and bit 3 = 1 selects the register file. For groups, bit 2 selects the post-queue pair (1) or the pre-queue pair (0).
- R2: Opcode bit 1 adds 1 to the packet counter of the selected pair, and opcode bit 0 adds the zero-extended data to its byte counter. Both may be set together. Within a group, the debug word slot is {bit2, byte} (0 pre-packet, 1 pre-byte, 2 post-packet, 3 post-byte), at debug address index*4+slot.
- R3: Groups with index below LOCAL_GROUPS (128) are updated on chip at one command per cycle. Back-to-back commands to the same counter all accumulate.
- R4: Groups at or above LOCAL_GROUPS are updated in external memory at word address index*4+slot. Each touched counter gets a read followed by a write of the read value plus the increment, with the packet counter done first. cmd_pop stays low until the final write is acknowledged.
- R5: Opcode 1010 adds 1 to register (index mod 64), and 1001 adds the data to register (index mod 64).
- R6: Opcode 1011 clears bit 0 of (index mod 64) to form a base. The even register at the base gets +1 and the odd register at base+1 gets +data.
- R7: Opcodes 0x00 (0000, 0100), 1000 and 11xx are popped and dropped. Each one raises err_count by one and touches no storage and no external memory.
- R8: All counters and registers are 32 bits wide and wrap modulo 2^32.
- R9: After reset, all on-chip counters, registers and err_count read zero, and ext_req is low.
- R10: dbg_data returns, in the same cycle, the register (dbg_is_reg=1, address mod 64) or the on-chip counter word (dbg_is_reg=0) named by dbg_addr.
- R11: Once ext_req is raised, ext_req, ext_we and ext_addr hold steady until ext_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | FIFO holds a command |
| cmd_data | input | 32 | Command word at FIFO head |
| cmd_pop | output | 1 | Engine takes the head word this cycle |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 18 | External word address (index*4+slot) |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data, valid with ext_ack |
| ext_ack | input | 1 | External access done |
| dbg_is_reg | input | 1 | Debug read targets the register file |
| dbg_addr | input | 9 | Debug word address |
| dbg_data | output | 32 | Debug read data |
| err_count | output | 16 | Count of dropped commands |

## Verification
On every cycle, assertions check three things: the FIFO is never popped while an external update is in flight, the external request holds its address and direction until it is acknowledged, and a dropped command raises the error count by exactly one. A further assertion checks that an on-chip packet update lands as the previous value plus one. The bench's scenarios are needed to show the end results: the arithmetic across every opcode and several indices, the pair formation for odd register indices, the wrap at 2^32 (using preloaded external words), accumulation under back-to-back traffic, and the fact that dropped commands leave the external memory untouched.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int CNT_W  = 32;
  localparam int DATA_W = 12;
  localparam int IDX_W  = 16;

  typedef struct packed {
    logic              ok;
    logic              is_reg;
    logic              post;
    logic              inc;
    logic              add;
    logic [DATA_W-1:0] data;
    logic [IDX_W-1:0]  idx;
  } upd_t;

  // Field split and legality of a command word (R1, R7)
  function automatic upd_t f_decode(logic [31:0] w);
    upd_t u;
    logic [3:0] op;
    op       = w[31:28];
    u.data   = w[27:16];
    u.idx    = w[15:0];
    u.is_reg = op[3];
    u.post   = op[2];
    u.inc    = op[1];
    u.add    = op[0];
    u.ok     = (op[1:0] != 2'b00) && (!op[3] || !op[2]);
    return u;
  endfunction

  function automatic logic [CNT_W-1:0] f_zext(logic [DATA_W-1:0] d);
    return {{(CNT_W-DATA_W){1'b0}}, d};
  endfunction

  // Modulo 2^32 bump (R8)
  function automatic logic [CNT_W-1:0] f_bump(logic [CNT_W-1:0] old, logic [CNT_W-1:0] amt);
    return old + amt;
  endfunction
endpackage

// File: rtl/stats_local_store.sv
module stats_local_store
  import stats_pkg::*;
#(
  parameter int LOCAL_GROUPS = 128,
  parameter int REG_WORDS    = 64,
  parameter int DBG_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  upd_t             upd,
  input  logic             dbg_is_reg,
  input  logic [DBG_W-1:0] dbg_addr,
  output logic [CNT_W-1:0] dbg_data
);
  localparam int CWORDS = LOCAL_GROUPS * 4;
  localparam int CAW    = $clog2(CWORDS);
  localparam int GAW    = $clog2(LOCAL_GROUPS);
  localparam int RAW    = $clog2(REG_WORDS);

  logic [CNT_W-1:0] cnt_q [CWORDS];
  logic [CNT_W-1:0] reg_q [REG_WORDS];

  logic [CAW-1:0]   c_pkt_a, c_byte_a;
  logic [RAW-1:0]   r_pkt_a, r_byte_a, r_base;
  logic             c_pkt_we, c_byte_we, r_pkt_we, r_byte_we, r_pair;
  logic [CNT_W-1:0] amt, pkt_old;

  always_comb begin
    amt       = f_zext(upd.data);
    c_pkt_a   = {upd.idx[GAW-1:0], upd.post, 1'b0};
    c_byte_a  = {upd.idx[GAW-1:0], upd.post, 1'b1};
    r_pair    = upd.inc && upd.add;
    r_base    = {upd.idx[RAW-1:1], 1'b0};
    r_pkt_a   = r_pair ? r_base : upd.idx[RAW-1:0];
    r_byte_a  = r_pair ? (r_base | RAW'(1)) : upd.idx[RAW-1:0];
    c_pkt_we  = upd_en && !upd.is_reg && upd.inc;
    c_byte_we = upd_en && !upd.is_reg && upd.add;
    r_pkt_we  = upd_en && upd.is_reg && upd.inc;
    r_byte_we = upd_en && upd.is_reg && upd.add;
    pkt_old   = cnt_q[c_pkt_a];
  end

  // Same-cycle read-modify-write on flop storage: no hazard between
  // consecutive commands, so no forwarding path is needed (R3)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CWORDS; i++) cnt_q[i] <= '0;
      for (int i = 0; i < REG_WORDS; i++) reg_q[i] <= '0;
    end else begin
      if (c_pkt_we)  cnt_q[c_pkt_a]  <= f_bump(cnt_q[c_pkt_a], 32'd1);
      if (c_byte_we) cnt_q[c_byte_a] <= f_bump(cnt_q[c_byte_a], amt);
      if (r_pkt_we)  reg_q[r_pkt_a]  <= f_bump(reg_q[r_pkt_a], 32'd1);
      if (r_byte_we) reg_q[r_byte_a] <= f_bump(reg_q[r_byte_a], amt);
    end
  end

  assign dbg_data = dbg_is_reg ? reg_q[dbg_addr[RAW-1:0]] : cnt_q[dbg_addr[CAW-1:0]];

  // R3: a local packet update lands as old value plus one
  a_r3_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
    c_pkt_we |=> cnt_q[$past(c_pkt_a)] == $past(pkt_old) + 32'd1);
endmodule

// File: rtl/stats_ext_seq.sv
module stats_ext_seq
  import stats_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  upd_t             cmd_in,
  output logic             busy,
  output logic             ext_req,
  output logic             ext_we,
  output logic [17:0]      ext_addr,
  output logic [CNT_W-1:0] ext_wdata,
  input  logic [CNT_W-1:0] ext_rdata,
  input  logic             ext_ack
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              post_q, add_q, on_byte_q;
  logic [CNT_W-1:0]  wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      data_q    <= '0;
      post_q    <= 1'b0;
      add_q     <= 1'b0;
      on_byte_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          idx_q     <= cmd_in.idx;
          data_q    <= cmd_in.data;
          post_q    <= cmd_in.post;
          add_q     <= cmd_in.add;
          on_byte_q <= !cmd_in.inc;  // packet counter goes first (R4)
          st_q      <= S_RD;
        end
        S_RD: if (ext_ack) begin
          wdata_q <= f_bump(ext_rdata, on_byte_q ? f_zext(data_q) : 32'd1);
          st_q    <= S_WR;
        end
        S_WR: if (ext_ack) begin
          if (!on_byte_q && add_q) begin
            on_byte_q <= 1'b1;
            st_q      <= S_RD;
          end else begin
            st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign ext_req   = busy;
  assign ext_we    = (st_q == S_WR);
  assign ext_addr  = {idx_q, post_q, on_byte_q};
  assign ext_wdata = wdata_q;

  // R4: an acknowledged read is always followed by the matching write
  a_r4_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_we && ext_ack |=> ext_req && ext_we && $stable(ext_addr));
endmodule

// File: rtl/stats_engine.sv
module stats_engine
  import stats_pkg::*;
#(
  parameter int LOCAL_GROUPS = 128,
  parameter int REG_WORDS    = 64,
  parameter int ERR_W        = 16,
  parameter int DBG_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_data,
  output logic             cmd_pop,
  output logic             ext_req,
  output logic             ext_we,
  output logic [17:0]      ext_addr,
  output logic [31:0]      ext_wdata,
  input  logic [31:0]      ext_rdata,
  input  logic             ext_ack,
  input  logic             dbg_is_reg,
  input  logic [DBG_W-1:0] dbg_addr,
  output logic [31:0]      dbg_data,
  output logic [ERR_W-1:0] err_count
);
  upd_t dec;
  logic is_far, ext_busy;
  logic evt_take, evt_drop, evt_local, evt_ext;

  assign dec       = f_decode(cmd_data);
  assign is_far    = !dec.is_reg && (dec.idx >= 16'(LOCAL_GROUPS));
  assign cmd_pop   = cmd_valid && !ext_busy;
  assign evt_take  = cmd_valid && cmd_pop;
  assign evt_drop  = evt_take && !dec.ok;
  assign evt_local = evt_take && dec.ok && !is_far;
  assign evt_ext   = evt_take && dec.ok && is_far;

  stats_local_store #(
    .LOCAL_GROUPS(LOCAL_GROUPS), .REG_WORDS(REG_WORDS), .DBG_W(DBG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .upd_en(evt_local), .upd(dec),
    .dbg_is_reg(dbg_is_reg), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  stats_ext_seq u_ext (
    .clk(clk), .rst_n(rst_n), .start(evt_ext), .cmd_in(dec), .busy(ext_busy),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_count <= '0;
    else if (evt_drop) err_count <= err_count + 1'b1;
  end

  // R4: the FIFO is held while an external update is in flight
  a_r4_stall_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !cmd_pop);
  // R11: request held steady until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we));
  // R7: each dropped command counts exactly once
  a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> err_count == $past(err_count) + 1'b1);
  // R7: a dropped command never starts an external access
  a_r7_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |-> !evt_ext);
endmodule

// File: tb/stats_engine_test.sv
module stats_engine_test;
  localparam int LG = 128;
  localparam int RW = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_pop;
  logic        ext_req, ext_we;
  logic [17:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;
  logic        ext_ack;
  logic        dbg_is_reg;
  logic [8:0]  dbg_addr;
  logic [31:0] dbg_data;
  logic [15:0] err_count;

  always #10 clk = ~clk;

  stats_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
    .dbg_is_reg(dbg_is_reg), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .err_count(err_count)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] e_cnt [LG*4];
  logic [31:0] e_reg [RW];
  logic [31:0] e_ext [int];
  logic [31:0] emem  [int];
  int e_err = 0;
  int lat;

  // external memory model: two wait cycles, then acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      ext_ack <= 1'b0; lat <= 0; ext_rdata <= '0;
    end else if (ext_ack) begin
      ext_ack <= 1'b0;
    end else if (ext_req) begin
      if (lat == 2) begin
        lat <= 0; ext_ack <= 1'b1;
        if (ext_we) emem[int'(ext_addr)] = ext_wdata;
        else ext_rdata <= emem.exists(int'(ext_addr)) ? emem[int'(ext_addr)] : 32'd0;
      end else lat <= lat + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_get(int k);
    return e_ext.exists(k) ? e_ext[k] : 32'd0;
  endfunction

  // bench's own statement of the update rules
  function automatic void model(logic [31:0] c);
    logic [3:0] op = c[31:28];
    int d = int'(c[27:16]);
    int ix = int'(c[15:0]);
    int side = op[2] ? 2 : 0;
    if (!op[3] && op[1:0] != 2'b00) begin          // R1 R2
      if (ix < LG) begin
        if (op[1]) e_cnt[ix*4+side]   = e_cnt[ix*4+side] + 1;
        if (op[0]) e_cnt[ix*4+side+1] = e_cnt[ix*4+side+1] + d;
      end else begin                                // R4
        if (op[1]) e_ext[ix*4+side]   = ext_get(ix*4+side) + 1;
        if (op[0]) e_ext[ix*4+side+1] = ext_get(ix*4+side+1) + d;
      end
    end else if (op[3:2] == 2'b10 && op[1:0] != 2'b00) begin
      int r = ix % RW;
      if (op == 4'hB) begin                         // R6
        int b = r - (r % 2);
        e_reg[b]   = e_reg[b] + 1;
        e_reg[b+1] = e_reg[b+1] + d;
      end else if (op[1]) e_reg[r] = e_reg[r] + 1;  // R5
      else e_reg[r] = e_reg[r] + d;
    end else e_err++;                               // R7
  endfunction

  task automatic send(logic [31:0] c, output int waited);
    waited = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = c;
    #1;
    while (!cmd_pop) begin @(negedge clk); #1; waited++; end
    @(posedge clk);
    model(c);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic preload(int k, logic [31:0] v);
    emem[k] = v; e_ext[k] = v;
  endtask

  task automatic compare_all();
    for (int i = 0; i < LG*4; i++) begin
      @(negedge clk); dbg_is_reg = 1'b0; dbg_addr = 9'(i); #1;
      chk("R2 R3 R10 local counter", dbg_data, e_cnt[i]);
    end
    for (int i = 0; i < RW; i++) begin
      @(negedge clk); dbg_is_reg = 1'b1; dbg_addr = 9'(i); #1;
      chk("R5 R6 R10 register", dbg_data, e_reg[i]);
    end
    foreach (e_ext[k]) chk("R4 R8 external word", emem.exists(k) ? emem[k] : 32'd0, e_ext[k]);
    chk("R7 err_count", 32'(err_count), 32'(e_err));
  endtask

  initial begin
    int w;
    int idxs [4] = '{0, 5, 127, 62};
    for (int i = 0; i < LG*4; i++) e_cnt[i] = '0;
    for (int i = 0; i < RW; i++) e_reg[i] = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; dbg_is_reg = 1'b0; dbg_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    @(negedge clk); #1;
    chk("R9 err_count", 32'(err_count), 32'd0);
    chk("R9 ext_req", 32'(ext_req), 32'd0);
    dbg_addr = 9'd7; #1 chk("R9 counter", dbg_data, 32'd0);
    dbg_is_reg = 1'b1; #1 chk("R9 register", dbg_data, 32'd0);

    // R1 R2 R5 R6 R7: every opcode over several indices (odd 5 and 127 for R6)
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 16; op++)
        send({4'(op), 12'((op*37 + k*101 + 3) & 12'hfff), 16'(idxs[k])}, w);

    // R3 back-to-back to one counter group
    for (int n = 0; n < 10; n++) begin
      send({4'h3, 12'(n + 1), 16'd3}, w);
      if (n > 0) chk("R3 one per cycle", 32'(w), 32'd0);
    end
    send({4'h7, 12'hfff, 16'd3}, w);
    send({4'h6, 12'h001, 16'd3}, w);

    // R4 R8 external groups, with wrap from preloaded values
    preload(200*4 + 0, 32'hFFFF_FFFF);
    preload(200*4 + 1, 32'hFFFF_FFF0);
    send({4'h3, 12'h020, 16'd200}, w);
    send({4'h1, 12'h123, 16'd128}, w);
    chk("R4 stall behind external", 32'(w > 0), 32'd1);
    send({4'h2, 12'h000, 16'd65535}, w);
    chk("R4 stall behind external", 32'(w > 0), 32'd1);
    send({4'h7, 12'h0ab, 16'd300}, w);
    send({4'h5, 12'h00c, 16'd300}, w);
    send({4'h6, 12'h000, 16'd300}, w);
    send({4'h2, 12'h000, 16'd127}, w);   // local again after external
    // R7 illegal opcode on an external index touches nothing
    send({4'h0, 12'h055, 16'd500}, w);
    send({4'hC, 12'h055, 16'd501}, w);
    repeat (40) @(negedge clk);
    chk("R7 external untouched", 32'(emem.exists(500*4) || emem.exists(500*4+1)
                                        || emem.exists(501*4+2)), 32'd0);
    chk("R11 request released", 32'(ext_req), 32'd0);
    compare_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule